// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block produces the status byte that a NOR flash returns on its data pins while an internal program or erase algorithm runs, and the array byte when nothing is in progress. It watches a simplified bus (active-low chip enable, output enable and write enable) and a handful of signals from a simulated program/erase engine: busy, operation kind, suspend, completion, protected-sector hit and pulse-limit overrun. The block does not model the cell array, analog timing or charge pumps. The caller supplies the array byte, and the block only decides what the pins show.

A read strobe is the cycle in which chip enable and output enable are first seen low together. At each strobe the block captures one byte into its output register. It holds that byte until the next strobe. Bit 7 is the polling bit, bit 6 is the toggle bit, bit 5 is the overrun flag, and bits 4..0 read 0 in every status byte.

Status reporting opens only once the command sequence has delivered enough write pulses. Two fixed-length periods of pseudo-activity cover protected targets. A pulse-limit overrun locks the block until reset. All durations are counted in clock cycles, scaled by a cycles-per-microsecond parameter.

Top module: `flash_status_gen`

## Requirements
- R1: When no status condition applies, a read strobe captures `array_data` into `dq_out`. `dq_out` keeps its value between strobes, and `dq_oe` is high exactly while `ce_n` and `oe_n` are both low.
- R2: While `eng_busy` is high, status is reported only after the required number of `we_n` rising edges have been counted: `PROG_WRITES` (default 4) when `eng_erase`=0, and `ERASE_WRITES` (default 6) when `eng_erase`=1. Before that count is reached, reads return array data.
- R3: Every strobe that reports active status puts on bit 6 the inverse of the toggle state left by the previous status read, then inverts that state. The toggle state is 0 after reset. Busy, including the sector-erase time-out window, keeps the toggle running.
- R4: In an active status byte, bit 7 is the inverse of `prog_msb` for a program and 0 for an erase. Bit 5 and bits 4..0 are 0.
- R5: A pulse on `eng_prot` with `eng_erase`=0 starts pseudo-activity lasting `CYC_PER_US*PROG_US` cycles. During it, reads give toggling status with bit 7 equal to the inverse of `prog_msb`. After it, reads return array data and the write-pulse count is cleared.
- R6: A pulse on `eng_prot` with `eng_erase`=1 (all selected sectors protected) starts pseudo-activity lasting `CYC_PER_US*ERASE_US` cycles, with bit 7 equal to 0. Reads then return array data.
- R7: While busy, gated open, `eng_susp`=1 and `eng_erase`=1 (erase suspended), reads return bit 7 = 1 and bit 6 equal to the frozen toggle state, and the toggle does not advance. With `eng_susp`=1 and `eng_erase`=0 (program inside the suspend), reads toggle again.
- R8: A pulse on `eng_limit` locks the block until reset. Every read then gives bit 5 = 1, a toggling bit 6, and bit 7 that is never the true data (the inverse of `prog_msb` for a program, 0 for an erase). Completion has no effect on this.
- R9: The first read after an `eng_done` pulse, once the gate is closed, gives bit 7 = `array_data[7]`, bit 6 toggled once more, and bits 5..0 = 0. The following read returns the full `array_data`.
- R10: Reset clears the output byte to 0, the toggle state to 0, the lock, the pseudo-activity timer, the completion flag and the write-pulse count.
- R11: The write-pulse count is cleared by `eng_done`. The status sources have this priority: lock, then pseudo-activity, then busy (suspended or not), then completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; each rising edge counts one command write |
| eng_busy | input | 1 | Engine is running an algorithm (includes erase time-out window) |
| eng_erase | input | 1 | Current operation kind: 1 erase, 0 program |
| eng_susp | input | 1 | Erase suspend in effect |
| eng_done | input | 1 | One-cycle pulse: algorithm finished |
| eng_prot | input | 1 | One-cycle pulse: target protected, start pseudo-activity |
| eng_limit | input | 1 | One-cycle pulse: internal pulse-count limit exceeded |
| prog_msb | input | 1 | Most significant bit of the byte being programmed |
| array_data | input | 8 | Array byte at the read address |
| dq_out | output | 8 | Byte captured at the last read strobe |
| dq_oe | output | 1 | Output drive enable |

## Verification
The toggle bit is driven through program, erase, suspend, suspend-program, protected pseudo-activity and lockout runs. Each run comes with back-to-back reads, so bit 6 separates a design that inverts per strobe from one that freezes or inverts per cycle. Write-pulse counts one short of the gate (3 for program, 5 for erase) and exactly at it show where reporting opens. A completion followed by two reads separates the early bit-7 byte from the full array byte. The protected-erase window is sampled well inside and just past its length, which shows the two durations are chosen by operation kind, and a second reset after lockout shows the lock goes away only on reset.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    RK_ARRAY,
    RK_LOCKED,
    RK_PSEUDO,
    RK_ACTIVE,
    RK_FROZEN,
    RK_FINAL
  } rkind_t;

  // Write pulses the command sequence must deliver before status opens.
  function automatic int needed_pulses(input logic is_erase, input int prog_n, input int erase_n);
    return is_erase ? erase_n : prog_n;
  endfunction

  // Length of protected-target pseudo-activity in clock cycles.
  function automatic int pseudo_cycles(input logic is_erase, input int cyc_per_us,
                                       input int prog_us, input int erase_us);
    return cyc_per_us * (is_erase ? erase_us : prog_us);
  endfunction

  // Polling bit shown while an algorithm is still running.
  function automatic logic poll_bit(input logic is_erase, input logic data_msb);
    return is_erase ? 1'b0 : ~data_msb;
  endfunction

  function automatic logic [7:0] status_word(input logic b7, input logic b6, input logic b5);
    return {b7, b6, b5, 5'b00000};
  endfunction

endpackage

// File: rtl/fsg_wcount.sv
module fsg_wcount #(
  parameter int MAXV = 6,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic          clr,
  output logic [CW-1:0] count
);

  logic we_prev;
  logic pulse_end;

  assign pulse_end = we_n && !we_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev <= 1'b1;
      count   <= '0;
    end else begin
      we_prev <= we_n;
      if (clr)
        count <= '0;
      else if (pulse_end && count != CW'(MAXV))
        count <= count + CW'(1);
    end
  end

  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAXV));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pulse_end && count < CW'(MAXV)) |=> count == $past(count) + CW'(1));

  a_r11_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

endmodule

// File: rtl/fsg_ptimer.sv
module fsg_ptimer #(
  parameter int CYC_PER_US = 50,
  parameter int PROG_US    = 1,
  parameter int ERASE_US   = 400,
  localparam int PN        = CYC_PER_US * PROG_US,
  localparam int EN        = CYC_PER_US * ERASE_US,
  localparam int LONGEST   = (EN > PN) ? EN : PN,
  localparam int TW        = $clog2(LONGEST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  output logic active,
  output logic expire,
  output logic kind_erase
);
  import fsg_pkg::*;

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left       <= '0;
      kind_erase <= 1'b0;
    end else if (start) begin
      left       <= TW'(pseudo_cycles(start_erase, CYC_PER_US, PROG_US, ERASE_US));
      kind_erase <= start_erase;
    end else if (left != '0) begin
      left <= left - TW'(1);
    end
  end

  assign active = (left != '0);
  assign expire = (left == TW'(1));

  a_r5_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);

  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> left == $past(left) - TW'(1));

  a_r6_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !active);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int CYC_PER_US   = 50,
  parameter int PROG_US      = 1,
  parameter int ERASE_US     = 400,
  parameter int PROG_WRITES  = 4,
  parameter int ERASE_WRITES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       eng_busy,
  input  logic       eng_erase,
  input  logic       eng_susp,
  input  logic       eng_done,
  input  logic       eng_prot,
  input  logic       eng_limit,
  input  logic       prog_msb,
  input  logic [7:0] array_data,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  import fsg_pkg::*;

  localparam int WMAX = (ERASE_WRITES > PROG_WRITES) ? ERASE_WRITES : PROG_WRITES;
  localparam int CW   = $clog2(WMAX + 1);

  logic          rd_act, rd_prev, rd_start;
  logic [CW-1:0] wcnt;
  logic          pz_active, pz_expire, pz_erase;
  logic          tog, fin, lock, lk_erase;
  logic [7:0]    dq_q;
  logic          gate_open;
  rkind_t        kind;
  logic [7:0]    next_byte;
  logic          flips;

  assign rd_act   = !ce_n && !oe_n;
  assign rd_start = rd_act && !rd_prev;
  assign dq_oe    = rd_act;
  assign dq_out   = dq_q;

  fsg_wcount #(.MAXV(WMAX)) u_wcount (
    .clk   (clk),
    .rst_n (rst_n),
    .we_n  (we_n),
    .clr   (eng_done || pz_expire),
    .count (wcnt)
  );

  fsg_ptimer #(.CYC_PER_US(CYC_PER_US), .PROG_US(PROG_US), .ERASE_US(ERASE_US)) u_ptimer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (eng_prot),
    .start_erase (eng_erase),
    .active      (pz_active),
    .expire      (pz_expire),
    .kind_erase  (pz_erase)
  );

  assign gate_open = eng_busy &&
                     (int'(wcnt) >= needed_pulses(eng_erase, PROG_WRITES, ERASE_WRITES));

  always_comb begin
    if (lock)                                kind = RK_LOCKED;
    else if (pz_active)                      kind = RK_PSEUDO;
    else if (gate_open && eng_susp && eng_erase) kind = RK_FROZEN;
    else if (gate_open)                      kind = RK_ACTIVE;
    else if (fin)                            kind = RK_FINAL;
    else                                     kind = RK_ARRAY;
  end

  always_comb begin
    next_byte = array_data;
    flips     = 1'b1;
    case (kind)
      RK_LOCKED: next_byte = status_word(poll_bit(lk_erase, prog_msb), ~tog, 1'b1);
      RK_PSEUDO: next_byte = status_word(poll_bit(pz_erase, prog_msb), ~tog, 1'b0);
      RK_ACTIVE: next_byte = status_word(poll_bit(eng_erase, prog_msb), ~tog, 1'b0);
      RK_FROZEN: begin
        next_byte = status_word(1'b1, tog, 1'b0);
        flips     = 1'b0;
      end
      RK_FINAL:  next_byte = status_word(array_data[7], ~tog, 1'b0);
      default:   flips = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      tog      <= 1'b0;
      fin      <= 1'b0;
      lock     <= 1'b0;
      lk_erase <= 1'b0;
      dq_q     <= '0;
    end else begin
      rd_prev <= rd_act;
      if (rd_start) begin
        dq_q <= next_byte;
        if (flips) tog <= ~tog;
      end
      if (eng_done)
        fin <= 1'b1;
      else if (rd_start && kind == RK_FINAL)
        fin <= 1'b0;
      if (eng_limit && !lock) begin
        lock     <= 1'b1;
        lk_erase <= eng_erase;
      end
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(dq_out));

  a_r1_array: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && kind == RK_ARRAY) |=> dq_out == $past(array_data));

  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && (kind == RK_ACTIVE || kind == RK_PSEUDO || kind == RK_LOCKED))
      |=> tog != $past(tog));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && kind == RK_FROZEN) |=> $stable(tog) && dq_out[7] && !dq_out[5]);

  a_r8_dq5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && lock) |=> dq_out[5]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  a_r9_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && kind == RK_FINAL)
      |=> dq_out[7] == $past(array_data[7]) && dq_out[5:0] == 6'd0);

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int PUS = 1;
  localparam int EUS = 400;
  localparam int PW  = 4;
  localparam int EW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic eng_busy = 1'b0, eng_erase = 1'b0, eng_susp = 1'b0;
  logic eng_done = 1'b0, eng_prot = 1'b0, eng_limit = 1'b0;
  logic prog_msb = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run_over = 1'b0;
  string phase = "R10";

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_status_gen #(
    .CYC_PER_US(CPU), .PROG_US(PUS), .ERASE_US(EUS),
    .PROG_WRITES(PW), .ERASE_WRITES(EW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .eng_busy(eng_busy), .eng_erase(eng_erase), .eng_susp(eng_susp),
    .eng_done(eng_done), .eng_prot(eng_prot), .eng_limit(eng_limit),
    .prog_msb(prog_msb), .array_data(array_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Behavioural reference: what the pins should show, from the requirements.
  int m_cnt, m_pleft;
  bit m_tog, m_fin, m_lock, m_lkerase, m_perase, m_rdprev, m_weprev;
  logic [7:0] m_dq;

  always @(posedge clk) begin
    bit strobe, rise, gate;
    int need;
    if (!rst_n) begin
      m_cnt = 0; m_pleft = 0; m_tog = 0; m_fin = 0; m_lock = 0;
      m_lkerase = 0; m_perase = 0; m_rdprev = 0; m_weprev = 1; m_dq = 8'h00;
    end else begin
      strobe = !ce_n && !oe_n && !m_rdprev;
      rise   = we_n && !m_weprev;
      need   = eng_erase ? EW : PW;
      gate   = eng_busy && (m_cnt >= need);
      if (strobe) begin
        if (m_lock) begin
          m_dq = {(m_lkerase ? 1'b0 : !prog_msb), !m_tog, 1'b1, 5'b0}; m_tog = !m_tog;
        end else if (m_pleft > 0) begin
          m_dq = {(m_perase ? 1'b0 : !prog_msb), !m_tog, 6'b0}; m_tog = !m_tog;
        end else if (gate && eng_susp && eng_erase) begin
          m_dq = {1'b1, m_tog, 6'b0};
        end else if (gate) begin
          m_dq = {(eng_erase ? 1'b0 : !prog_msb), !m_tog, 6'b0}; m_tog = !m_tog;
        end else if (m_fin) begin
          m_dq = {array_data[7], !m_tog, 6'b0}; m_tog = !m_tog; m_fin = 0;
        end else begin
          m_dq = array_data;
        end
      end
      if (eng_done) m_fin = 1;
      if (eng_limit && !m_lock) begin m_lock = 1; m_lkerase = eng_erase; end
      if (eng_done || m_pleft == 1) m_cnt = 0;
      else if (rise && m_cnt < EW) m_cnt++;
      if (eng_prot) begin
        m_pleft = CPU * (eng_erase ? EUS : PUS); m_perase = eng_erase;
      end else if (m_pleft > 0) m_pleft--;
      m_rdprev = !ce_n && !oe_n;
      m_weprev = we_n;
    end
  end

  // Compare against the reference on every clock, away from the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (rst_n && !run_over) begin
      checks++;
      if (dq_out !== m_dq || dq_oe !== (!ce_n && !oe_n)) begin
        errors++;
        $display("FAIL %s per-cycle: dq_out=%h dq_oe=%b expected %h %b",
                 phase, dq_out, dq_oe, m_dq, (!ce_n && !oe_n));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !run_over) begin
      run_over = 1'b1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dq_out; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_prot();
    @(negedge clk); eng_prot = 1'b1;
    @(negedge clk); eng_prot = 1'b0;
  endtask

  task automatic pulse_limit();
    @(negedge clk); eng_limit = 1'b1;
    @(negedge clk); eng_limit = 1'b0;
  endtask

  initial begin
    logic [7:0] v, v2;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R10 reset dq_out", dq_out, 8'h00);
    chk("R10 reset dq_oe", {7'd0, dq_oe}, 8'h00);

    phase = "R1";
    array_data = 8'hA5; do_read(v); chk("R1 idle read", v, 8'hA5);
    array_data = 8'h3C; do_read(v); chk("R1 idle read 2", v, 8'h3C);

    phase = "R2";
    eng_busy = 1'b1; eng_erase = 1'b0; prog_msb = 1'b1;
    wr_pulses(3); do_read(v); chk("R2 program gate closed at 3", v, 8'h3C);
    wr_pulses(1);
    phase = "R3";
    do_read(v); chk("R4 program status first", v, 8'h40);
    do_read(v2); chk("R3 toggle inverts", v2, 8'h00);

    phase = "R9";
    eng_busy = 1'b0; array_data = 8'hD7; pulse_done();
    do_read(v); chk("R9 early bit7", v, 8'hC0);
    do_read(v); chk("R9 full byte", v, 8'hD7);

    phase = "R11";
    eng_busy = 1'b1; eng_erase = 1'b0; prog_msb = 1'b0;
    wr_pulses(3); do_read(v); chk("R11 count cleared by done", v, 8'hD7);
    wr_pulses(1); do_read(v); chk("R4 program poll bit", v, 8'h80);
    eng_busy = 1'b0; pulse_done();
    do_read(v); chk("R9 early bit7 again", v, 8'hC0);
    do_read(v); chk("R9 full byte again", v, 8'hD7);

    phase = "R2";
    eng_busy = 1'b1; eng_erase = 1'b1;
    wr_pulses(5); do_read(v); chk("R2 erase gate closed at 5", v, 8'hD7);
    wr_pulses(1);
    phase = "R3";
    do_read(v); chk("R4 erase status", v, 8'h00);
    do_read(v); chk("R3 erase time-out toggling", v, 8'h40);

    phase = "R7";
    eng_susp = 1'b1;
    do_read(v); chk("R7 suspended frozen 1", v, 8'hC0);
    do_read(v); chk("R7 suspended frozen 2", v, 8'hC0);
    eng_erase = 1'b0; prog_msb = 1'b1;
    do_read(v); chk("R7 suspend-program toggles 1", v, 8'h00);
    do_read(v); chk("R7 suspend-program toggles 2", v, 8'h40);
    eng_susp = 1'b0; eng_erase = 1'b1;
    do_read(v); chk("R3 resumed erase", v, 8'h00);
    eng_busy = 1'b0; array_data = 8'h5A; pulse_done();
    do_read(v); chk("R9 erase done bit7", v, 8'h40);
    do_read(v); chk("R9 erase done byte", v, 8'h5A);

    phase = "R5";
    eng_erase = 1'b0; prog_msb = 1'b1;
    wr_pulses(4); pulse_prot();
    do_read(v); chk("R5 protected program status", v, 8'h00);
    tick(4); do_read(v); chk("R5 back to read", v, 8'h5A);
    eng_busy = 1'b1;
    do_read(v); chk("R5 count cleared at expiry", v, 8'h5A);
    eng_busy = 1'b0;

    phase = "R6";
    eng_erase = 1'b1; pulse_prot();
    do_read(v); chk("R6 protected erase status", v, 8'h40);
    tick(700); do_read(v); chk("R6 still active", v, 8'h00);
    tick(120); do_read(v); chk("R6 back to read", v, 8'h5A);

    phase = "R8";
    eng_busy = 1'b1; eng_erase = 1'b0; prog_msb = 1'b0;
    pulse_limit();
    do_read(v); chk("R8 lock status", v, 8'hE0);
    eng_busy = 1'b0; pulse_done();
    do_read(v); chk("R8 done ignored", v, 8'hA0);
    do_read(v); chk("R8 still toggling", v, 8'hE0);

    phase = "R10";
    @(negedge clk); rst_n = 1'b0;
    tick(2); rst_n = 1'b1;
    tick(1); chk("R10 reset after lock", dq_out, 8'h00);
    do_read(v); chk("R10 lock cleared", v, 8'h5A);

    tick(2);
    run_over = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule